// File: doc/BRIEF.md
# Frame Fault Injection Sequencer

This controller carries out a campaign of single-upset trials against a configuration memory that is organised as frames of 32-bit words and reached through a word-wide read/write port. For each trial it takes a target (frame, word, bit mask) from an external address generator. It reads every word of that frame into a local buffer and writes the frame back with the chosen bits inverted. Only after that does it enable the design under test and its golden twin for a programmed number of cycles. It watches their mismatch comparator over the whole window and updates saturating trial and failure counters. It then writes the untouched frame back while holding the design's flip-flops in reset.

In cumulative mode the sequencer keeps one frame locked and lets flips pile up from trial to trial without repair. Repair comes only when a trial fails or the campaign reaches its last trial. After a repair the next trial locks a fresh frame. A second buffer keeps the clean image captured on the first read of the locked frame, so a restore never needs another read.

Top module: `frame_fault_seq`

## Requirements
- R1: While reset is held, every output is low or zero: port commands, run enable, flip-flop reset, busy and done flags, target advance and both counters.
- R2: Each trial reads all WORDS words of the target frame through the port, at word indices 0 to WORDS-1 in ascending order, before it issues any write. Read data is valid on the cycle after the read command.
- R3: After the reads, the trial writes the same frame back at word indices 0 to WORDS-1 in ascending order. Each written word equals the word that was read, except that the target word is XORed with the target mask.
- R4: The run enable rises only after the last faulty write. It stays high for exactly the latched window length, and a length of zero counts as one cycle. No port command is issued while it is high.
- R5: A mismatch seen in any cycle of the window marks the trial as failed, and the failure counter then rises by exactly one.
- R6: A repair writes the clean frame words back at word indices 0 to WORDS-1. The flip-flop reset is high on every one of those WORDS write cycles and on no other cycle.
- R7: Outside cumulative mode every trial is repaired. In cumulative mode the frame address is taken only from the first trial after a repair, later trials flip bits in that locked frame, and a repair happens only after a failed trial or the last trial. When a campaign ends, the memory holds its original contents.
- R8: The trial and failure counters clear when a campaign is accepted and saturate at 2^CNT_W-1.
- R9: The target-advance output pulses once per trial. The trial-done output pulses at the end of each trial, and camp_done pulses on the cycle after the last trial-done. A campaign of zero trials raises camp_done on the cycle after it is accepted, with no trial.
- R10: A campaign start seen while a campaign is busy is ignored: the running campaign's settings and counters are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk on release |
| camp_start | input | 1 | Start a campaign (accepted only when idle) |
| camp_trials | input | TRW | Number of trials in the campaign |
| cum_mode | input | 1 | 1 selects cumulative accumulation |
| win_len | input | LW | Execution window length in cycles |
| tgt_frame | input | FAW | Target frame address from the generator |
| tgt_word | input | log2(WORDS) | Target word within the frame |
| tgt_mask | input | 32 | Bits to invert in the target word |
| tgt_next | output | 1 | Target consumed, generator may advance |
| cfg_rd | output | 1 | Configuration port read command |
| cfg_wr | output | 1 | Configuration port write command |
| cfg_addr | output | FAW+log2(WORDS) | Port address: frame above word index |
| cfg_rdata | input | 32 | Read data, one cycle after cfg_rd |
| cfg_wdata | output | 32 | Write data |
| run_en | output | 1 | Enable for design under test and golden copy |
| mismatch | input | 1 | Output comparator result |
| dut_rst | output | 1 | Reset to the design flip-flops during repair |
| trial_busy | output | 1 | A trial is in progress |
| trial_done | output | 1 | One-cycle pulse at trial end |
| camp_busy | output | 1 | A campaign is in progress |
| camp_done | output | 1 | One-cycle pulse at campaign end |
| trial_cnt | output | CNT_W | Saturating count of completed trials |
| fail_cnt | output | CNT_W | Saturating count of failed trials |

## Verification
Two pairs of functions meet in one cycle here. The first pair is the repair write and the flip-flop reset: the bench checks every write after the faulty pass for the clean word, the right address and a high reset. It also counts the reset cycles per trial against the number the repair rule predicts. The second pair is the final cycle of the execution window and the mismatch sample. Directed trials raise the comparator only on the first or only on the last window cycle, and random trials raise it at random offsets, some past the window. The expected failure count comes from whether that offset lies inside the latched length.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  localparam int PORT_W = 32;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_READ,
    S_RDLAST,
    S_WRITE,
    S_RUN,
    S_EVAL,
    S_FIX,
    S_END,
    S_FIN
  } seq_st_e;
endpackage

// File: rtl/ffs_sat_cnt.sv
module ffs_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)
      q_n = '0;
    else if (inc && (q != TOP))
      q_n = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q == $past(q)) || (q == $past(q) + 1'b1))); // R8
endmodule

// File: rtl/ffs_window.sv
module ffs_window #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic          clr,
  input  logic          mis,
  output logic          active,
  output logic          last,
  output logic          sticky
);
  logic [LW-1:0] cnt, cnt_n;
  logic          act_n, stk_n;

  assign last = active && (cnt == LW'(1));

  always_comb begin
    cnt_n = cnt;
    act_n = active;
    stk_n = sticky;
    if (load) begin
      cnt_n = (len == '0) ? LW'(1) : len;
      act_n = 1'b1;
    end else if (active) begin
      cnt_n = cnt - 1'b1;
      if (last) act_n = 1'b0;
    end
    if (clr)
      stk_n = 1'b0;
    else if (active && mis)
      stk_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      sticky <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      active <= act_n;
      sticky <= stk_n;
    end
  end

  AST_WIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(load)); // R4
  AST_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !active); // R4
endmodule

// File: rtl/ffs_frame_buf.sv
module ffs_frame_buf #(
  parameter int WORDS = 4,
  parameter int IW    = 2,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_clean,
  input  logic [IW-1:0] cap_idx,
  input  logic [DW-1:0] cap_data,
  input  logic [IW-1:0] rd_idx,
  input  logic [IW-1:0] flip_idx,
  input  logic [DW-1:0] flip_mask,
  output logic [DW-1:0] faulty_word,
  output logic [DW-1:0] clean_word
);
  logic [WORDS-1:0][DW-1:0] fbuf, fbuf_n;
  logic [WORDS-1:0][DW-1:0] cbuf, cbuf_n;

  always_comb begin
    fbuf_n = fbuf;
    cbuf_n = cbuf;
    if (cap_en) begin
      fbuf_n[cap_idx] = cap_data;
      if (cap_clean) cbuf_n[cap_idx] = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbuf <= '0;
      cbuf <= '0;
    end else begin
      fbuf <= fbuf_n;
      cbuf <= cbuf_n;
    end
  end

  assign faulty_word = fbuf[rd_idx] ^ ((rd_idx == flip_idx) ? flip_mask : '0);
  assign clean_word  = cbuf[rd_idx];
endmodule

// File: rtl/frame_fault_seq.sv
module frame_fault_seq
  import ffs_pkg::*;
#(
  parameter int FAW   = 6,
  parameter int WORDS = 4,
  parameter int CNT_W = 32,
  parameter int TRW   = 16,
  parameter int LW    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 camp_start,
  input  logic [TRW-1:0]                       camp_trials,
  input  logic                                 cum_mode,
  input  logic [LW-1:0]                        win_len,
  input  logic [FAW-1:0]                       tgt_frame,
  input  logic [((WORDS>1)?$clog2(WORDS):1)-1:0] tgt_word,
  input  logic [PORT_W-1:0]                    tgt_mask,
  output logic                                 tgt_next,
  output logic                                 cfg_rd,
  output logic                                 cfg_wr,
  output logic [FAW+((WORDS>1)?$clog2(WORDS):1)-1:0] cfg_addr,
  input  logic [PORT_W-1:0]                    cfg_rdata,
  output logic [PORT_W-1:0]                    cfg_wdata,
  output logic                                 run_en,
  input  logic                                 mismatch,
  output logic                                 dut_rst,
  output logic                                 trial_busy,
  output logic                                 trial_done,
  output logic                                 camp_busy,
  output logic                                 camp_done,
  output logic [CNT_W-1:0]                     trial_cnt,
  output logic [CNT_W-1:0]                     fail_cnt
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  seq_st_e        st, st_n;
  logic [IW-1:0]  widx, widx_n;
  logic [IW-1:0]  pend_idx;
  logic           pend;
  logic [TRW-1:0] left, left_n;
  logic           cum_q, cum_n;
  logic [LW-1:0]  wlen_q, wlen_n;
  logic [FAW-1:0] frame_q, frame_n;
  logic [IW-1:0]  word_q, word_n;
  logic [PORT_W-1:0] mask_q, mask_n;
  logic           fresh_q, fresh_n;

  logic cnt_clr, inc_trial, inc_fail;
  logic win_load, win_clr, win_last, sticky;
  logic [PORT_W-1:0] faulty_word, clean_word;

  // next-state process
  always_comb begin
    st_n      = st;
    widx_n    = widx;
    left_n    = left;
    cum_n     = cum_q;
    wlen_n    = wlen_q;
    frame_n   = frame_q;
    word_n    = word_q;
    mask_n    = mask_q;
    fresh_n   = fresh_q;
    cnt_clr   = 1'b0;
    inc_trial = 1'b0;
    inc_fail  = 1'b0;
    win_load  = 1'b0;
    win_clr   = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (camp_start) begin
          cum_n   = cum_mode;
          wlen_n  = win_len;
          left_n  = camp_trials;
          fresh_n = 1'b1;
          cnt_clr = 1'b1;
          st_n    = (camp_trials == '0) ? S_FIN : S_LOAD;
        end
      end
      S_LOAD: begin
        if (fresh_q) frame_n = tgt_frame;
        word_n  = tgt_word;
        mask_n  = tgt_mask;
        widx_n  = '0;
        win_clr = 1'b1;
        st_n    = S_READ;
      end
      S_READ: begin
        widx_n = widx + 1'b1;
        if (widx == LAST_IDX) begin
          widx_n = '0;
          st_n   = S_RDLAST;
        end
      end
      S_RDLAST: begin
        st_n = S_WRITE;
      end
      S_WRITE: begin
        widx_n = widx + 1'b1;
        if (widx == LAST_IDX) begin
          widx_n   = '0;
          win_load = 1'b1;
          fresh_n  = 1'b0;
          st_n     = S_RUN;
        end
      end
      S_RUN: begin
        if (win_last) st_n = S_EVAL;
      end
      S_EVAL: begin
        inc_trial = 1'b1;
        inc_fail  = sticky;
        left_n    = left - 1'b1;
        if (!cum_q || sticky || (left == TRW'(1))) begin
          fresh_n = 1'b1;
          st_n    = S_FIX;
        end else begin
          st_n    = S_END;
        end
      end
      S_FIX: begin
        widx_n = widx + 1'b1;
        if (widx == LAST_IDX) begin
          widx_n = '0;
          st_n   = S_END;
        end
      end
      S_END: begin
        st_n = (left == '0) ? S_FIN : S_LOAD;
      end
      S_FIN: begin
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      widx     <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
      left     <= '0;
      cum_q    <= 1'b0;
      wlen_q   <= '0;
      frame_q  <= '0;
      word_q   <= '0;
      mask_q   <= '0;
      fresh_q  <= 1'b0;
    end else begin
      st       <= st_n;
      widx     <= widx_n;
      pend     <= (st == S_READ);
      pend_idx <= widx;
      left     <= left_n;
      cum_q    <= cum_n;
      wlen_q   <= wlen_n;
      frame_q  <= frame_n;
      word_q   <= word_n;
      mask_q   <= mask_n;
      fresh_q  <= fresh_n;
    end
  end

  ffs_frame_buf #(.WORDS(WORDS), .IW(IW), .DW(PORT_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (pend),
    .cap_clean  (fresh_q),
    .cap_idx    (pend_idx),
    .cap_data   (cfg_rdata),
    .rd_idx     (widx),
    .flip_idx   (word_q),
    .flip_mask  (mask_q),
    .faulty_word(faulty_word),
    .clean_word (clean_word)
  );

  ffs_window #(.LW(LW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (win_load),
    .len   (wlen_q),
    .clr   (win_clr),
    .mis   (mismatch),
    .active(run_en),
    .last  (win_last),
    .sticky(sticky)
  );

  ffs_sat_cnt #(.W(CNT_W)) u_trials (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_trial), .q(trial_cnt)
  );

  ffs_sat_cnt #(.W(CNT_W)) u_fails (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(inc_fail), .q(fail_cnt)
  );

  assign cfg_rd     = (st == S_READ);
  assign cfg_wr     = (st == S_WRITE) || (st == S_FIX);
  assign cfg_addr   = {frame_q, widx};
  assign cfg_wdata  = (st == S_FIX) ? clean_word : faulty_word;
  assign dut_rst    = (st == S_FIX);
  assign tgt_next   = (st == S_LOAD);
  assign trial_done = (st == S_END);
  assign camp_done  = (st == S_FIN);
  assign camp_busy  = (st != S_IDLE);
  assign trial_busy = (st != S_IDLE) && (st != S_END) && (st != S_FIN);

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd && cfg_wr)); // R2
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (!cfg_rd && !cfg_wr)); // R4
  AST_RUN_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(cfg_wr)); // R4
  AST_RST_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    dut_rst |-> cfg_wr); // R6
  AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt <= trial_cnt); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trial_done, camp_done, tgt_next})); // R9
endmodule

// File: tb/frame_fault_seq_test.sv
module frame_fault_seq_test;
  localparam int FAW = 3, WORDS = 4, IW = 2, CNT_W = 4, TRW = 8, LW = 8;
  localparam int NFR = 8, MEMN = NFR * WORDS, NT = 128;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic camp_start = 1'b0;
  logic [TRW-1:0] camp_trials = '0;
  logic cum_mode = 1'b0;
  logic [LW-1:0] win_len = '0;
  logic [FAW-1:0] tgt_frame;
  logic [IW-1:0] tgt_word;
  logic [31:0] tgt_mask;
  logic tgt_next, cfg_rd, cfg_wr;
  logic [FAW+IW-1:0] cfg_addr;
  logic [31:0] cfg_rdata, cfg_wdata;
  logic run_en, mismatch, dut_rst;
  logic trial_busy, trial_done, camp_busy, camp_done;
  logic [CNT_W-1:0] trial_cnt, fail_cnt;

  logic [31:0] mem  [MEMN];
  logic [31:0] gold [MEMN];
  logic [31:0] emem [MEMN];
  int tf [NT];
  int tw [NT];
  logic [31:0] tm [NT];
  int fc [NT];
  int ti, rc, tcur;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  frame_fault_seq #(.FAW(FAW), .WORDS(WORDS), .CNT_W(CNT_W), .TRW(TRW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .camp_start(camp_start), .camp_trials(camp_trials),
    .cum_mode(cum_mode), .win_len(win_len), .tgt_frame(tgt_frame), .tgt_word(tgt_word),
    .tgt_mask(tgt_mask), .tgt_next(tgt_next), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .cfg_wdata(cfg_wdata), .run_en(run_en),
    .mismatch(mismatch), .dut_rst(dut_rst), .trial_busy(trial_busy), .trial_done(trial_done),
    .camp_busy(camp_busy), .camp_done(camp_done), .trial_cnt(trial_cnt), .fail_cnt(fail_cnt)
  );

  // generator index and configuration memory model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ti <= 0;
    else if (tgt_next) ti <= ti + 1;
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc <= 0;
    else if (trial_done) rc <= 0;
    else if (run_en) rc <= rc + 1;
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= gold[i];
      cfg_rdata <= '0;
    end else begin
      if (cfg_rd) cfg_rdata <= mem[cfg_addr];
      if (cfg_wr) mem[cfg_addr] <= cfg_wdata;
    end
  end

  assign tcur      = (ti == 0) ? 0 : ti - 1;
  assign tgt_frame = FAW'(tf[ti % NT]);
  assign tgt_word  = IW'(tw[ti % NT]);
  assign tgt_mask  = tm[ti % NT];
  assign mismatch  = run_en && (fc[tcur % NT] == rc);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  // monitor: expected behaviour derived from the requirements
  int c_tr, c_w, ct, nf, t, ef, rd_n, wr_n, run_n, rs_n, cdone;
  bit c_cum, bfresh;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) emem[i] = gold[i];
    end else begin
      if (camp_start && !camp_busy) begin
        c_tr = int'(camp_trials); c_cum = cum_mode;
        c_w = (win_len == 0) ? 1 : int'(win_len);
        ct = 0; nf = 0; bfresh = 1'b1;
      end
      if (tgt_next) begin
        t = ti;
        if (bfresh) ef = tf[t];
        rd_n = 0; wr_n = 0; run_n = 0; rs_n = 0;
      end
      if (cfg_rd) begin
        chk(wr_n == 0 && int'(cfg_addr) == ef * WORDS + rd_n, "R2 read order",
            cfg_addr, ef * WORDS + rd_n);
        rd_n++;
      end
      if (cfg_wr) begin
        if (wr_n < WORDS) begin
          automatic int ix = ef * WORDS + wr_n;
          automatic logic [31:0] ev = emem[ix] ^ ((wr_n == tw[t]) ? tm[t] : 32'h0);
          chk(int'(cfg_addr) == ix && cfg_wdata == ev && !dut_rst, "R3 faulty write",
              cfg_wdata, ev);
          if (wr_n == WORDS - 1) emem[ef * WORDS + tw[t]] ^= tm[t];
        end else begin
          automatic int ix = ef * WORDS + wr_n - WORDS;
          chk(int'(cfg_addr) == ix && cfg_wdata == gold[ix] && dut_rst, "R6 repair write",
              cfg_wdata, gold[ix]);
        end
        wr_n++;
      end
      if (dut_rst) rs_n++;
      if (run_en) begin
        if (run_n == 0) begin
          automatic bit same = 1'b1;
          for (int w = 0; w < WORDS; w++)
            if (mem[ef * WORDS + w] !== emem[ef * WORDS + w]) same = 1'b0;
          chk(same, "R3 frame faulty at run start", same, 1);
        end
        run_n++;
      end
      if (trial_done) begin
        automatic bit fl  = (fc[t] >= 0) && (fc[t] < c_w);
        automatic bit rep;
        ct++;
        if (fl) nf++;
        rep = !c_cum || fl || (ct == c_tr);
        chk(run_n == c_w, "R4 window length", run_n, c_w);
        chk(rd_n == WORDS, "R2 read count", rd_n, WORDS);
        chk(wr_n == (rep ? 2 * WORDS : WORDS), "R7 repair decision", wr_n,
            rep ? 2 * WORDS : WORDS);
        chk(rs_n == (rep ? WORDS : 0), "R6 reset cycles", rs_n, rep ? WORDS : 0);
        chk(int'(trial_cnt) == sat(ct), "R8 trial count", trial_cnt, sat(ct));
        chk(int'(fail_cnt) == sat(nf), "R5 fail count", fail_cnt, sat(nf));
        if (rep) begin
          automatic bit same = 1'b1;
          for (int w = 0; w < WORDS; w++) begin
            emem[ef * WORDS + w] = gold[ef * WORDS + w];
            if (mem[ef * WORDS + w] !== gold[ef * WORDS + w]) same = 1'b0;
          end
          chk(same, "R6 frame restored", same, 1);
          bfresh = 1'b1;
        end else begin
          bfresh = 1'b0;
        end
      end
      if (camp_done) begin
        automatic bit same = 1'b1;
        for (int i = 0; i < MEMN; i++) if (mem[i] !== gold[i]) same = 1'b0;
        chk(ct == c_tr, "R9 trials before camp_done", ct, c_tr);
        chk(same, "R7 memory clean at end", same, 1);
        cdone++;
      end
    end
  end

  task automatic run_camp(input int n, input bit cum, input int w, input bit poke);
    @(posedge clk); #1;
    camp_trials = TRW'(n); cum_mode = cum; win_len = LW'(w); camp_start = 1'b1;
    @(posedge clk); #1;
    camp_start = 1'b0;
    if (poke) begin
      repeat (2) @(posedge tgt_next);
      @(posedge clk); #1;
      camp_trials = 8'd1; cum_mode = ~cum; win_len = 8'd9; camp_start = 1'b1;
      @(posedge clk); #1;
      camp_start = 1'b0;
      @(negedge clk);
      chk(camp_busy, "R10 start ignored while busy", camp_busy, 1);
    end
    while (!camp_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    automatic int dummy = $urandom(32'd2718);
    cdone = 0;
    for (int i = 0; i < MEMN; i++) gold[i] = $urandom;
    for (int i = 0; i < NT; i++) begin
      tf[i] = int'($urandom % NFR);
      tw[i] = int'($urandom % WORDS);
      tm[i] = $urandom | 32'h1;
      fc[i] = int'($urandom % 7) - 1;
    end
    // directed: 0..2 non-cumulative, window 3, mismatch on first and on last cycle
    fc[0] = -1; fc[1] = 0; fc[2] = 2;
    // 3..8 cumulative window 2, one failure in the fourth trial
    for (int i = 3; i <= 8; i++) fc[i] = -1;
    fc[6] = 1;
    // 9..12 cumulative, never failing
    for (int i = 9; i <= 12; i++) fc[i] = -1;
    tw[9] = 1; tw[10] = 1; tm[10] = tm[9];
    dummy = dummy + 1;

    repeat (3) @(negedge clk);
    chk(!cfg_rd && !cfg_wr && !run_en && !dut_rst && !tgt_next && !trial_busy &&
        !trial_done && !camp_busy && !camp_done && trial_cnt == 0 && fail_cnt == 0,
        "R1 reset state", {cfg_rd, cfg_wr, run_en, dut_rst, camp_busy}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    run_camp(3, 1'b0, 3, 1'b0);
    run_camp(6, 1'b1, 2, 1'b0);
    run_camp(4, 1'b1, 1, 1'b0);
    run_camp(3, 1'b0, 0, 1'b0);
    run_camp(20, 1'b0, 5, 1'b0);
    // zero-trial campaign
    @(posedge clk); #1;
    camp_trials = '0; camp_start = 1'b1;
    @(posedge clk); #1;
    camp_start = 1'b0;
    @(negedge clk);
    chk(camp_done && !tgt_next, "R9 zero-trial done", camp_done, 1);
    @(negedge clk);
    run_camp(4, 1'b0, 2, 1'b1);
    run_camp(12, 1'b1, 3, 1'b0);
    chk(cdone == 8, "R9 campaign count", cdone, 8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog camp_done act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule